// File: doc/BRIEF.md
# Writeback Credit Issue Throttle

This block stops an out-of-order core from issuing more instructions than its writeback buffer can hold. The buffer takes `WB_WIDTH` results per cycle for `WB_DEPTH` cycles, so the block starts with `WB_WIDTH * WB_DEPTH` credits. Every instruction granted issue takes one credit. The credit comes back when that instruction leaves the machine by one of three routes:

- it writes back normally;
- it was squashed and is dropped in the execute stage;
- it was a squashed load whose memory response arrives late.

Each cycle the scheduler offers up to `ISSUE_W` issue requests. The block grants them lowest slot first until the free credits run out. It also drives a level signal that tells the scheduler whether issue is open at all. The grants and all returns of a cycle are folded into one net update of the outstanding count.

Two sticky flags report protocol faults. The first rises when the returns of a cycle exceed the credits in use. The second comes from an optional tag scoreboard: it rises when a return names a tag that is not outstanding. The scheduler, the functional units and the buffer storage belong elsewhere.

Top module: `wb_credit_throttle`

## Requirements
- R1: The credit limit is MAX = WB_WIDTH * WB_DEPTH (6 with defaults). The outstanding count never exceeds MAX. `iss_enable` is low exactly when the count equals MAX.
- R2: After reset the count is zero, `iss_enable` is high and both error flags are low.
- R3: Every granted slot raises the count by one at the next clock edge. Once the count reaches MAX, `iss_enable` is low and stays low until a return arrives.
- R4: A return that arrives while the count is at MAX makes `iss_enable` high in the following cycle.
- R5: Each valid bit on `wb_vld`, `sq_vld` or `ld_vld` lowers the count by one. All bits of all three sources, together with the grants, form a single net update each cycle.
- R6: The grant vector is the requested slots taken from bit 0 upward. At most min(ISSUE_W, MAX - count) slots are granted. No slot is granted without a request.
- R7: Credits returned in a cycle cannot be granted until the next cycle. At MAX, a return and requests in the same cycle give no grant.
- R8: If a cycle's returns exceed the count plus that cycle's grants, the count becomes zero and `cnt_err` rises and stays high until reset.
- R9: With TRACK_TAGS=1 the tag on each granted slot is recorded. A return whose tag was not recorded at the start of its cycle raises `tag_err`, which stays high until reset. A return clears its tag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| iss_req | input | ISSUE_W | Issue request per slot |
| iss_tag | input | ISSUE_W*TAG_W | Tag per issue slot, slot 0 in the low bits |
| iss_gnt | output | ISSUE_W | Issue grant per slot |
| iss_enable | output | 1 | Issue open (count below MAX) |
| wb_vld | input | WB_WIDTH | Normal writeback returns |
| wb_tag | input | WB_WIDTH*TAG_W | Tags of the writeback returns |
| sq_vld | input | SQ_PORTS | Squashed instructions dropped in execute |
| sq_tag | input | SQ_PORTS*TAG_W | Tags of the squash drops |
| ld_vld | input | LD_PORTS | Late responses for squashed loads |
| ld_tag | input | LD_PORTS*TAG_W | Tags of the late load responses |
| cnt_err | output | 1 | Sticky count underflow or overflow |
| tag_err | output | 1 | Sticky return of an unrecorded tag |

## Verification
The bench fills the block from empty in two cycles: first a full-width burst, then a burst that the limit cuts short. A design that ignores the limit would grant all four slots again and overflow the count. A design that grants from the top slot would pick the wrong slots.

At the full point it returns one credit on each source in turn while the slots keep requesting. A design that lets a credit be granted in the same cycle it returns would issue early. A design that ignores one source would stay blocked forever.

Random traffic then mixes grants with returns on all three sources at once, which exposes net-update errors. The run ends with two fault cases: a return of a tag that was never issued, and a return while the count is zero. A design that wraps the count instead of flagging it would reopen with a huge count.

// File: rtl/wbc_pkg.sv
package wbc_pkg;

   function automatic int unsigned wbc_min(input int unsigned a, input int unsigned b);
      return (a < b) ? a : b;
   endfunction

   function automatic int unsigned wbc_credit_max(input int unsigned width, input int unsigned depth);
      return width * depth;
   endfunction

endpackage

// File: rtl/wbc_popcount.sv
module wbc_popcount #(
   parameter int N = 4,
   parameter int W = 3
) (
   input  logic [N-1:0] bits_in,
   output logic [W-1:0] ones
);
   always_comb begin
      ones = '0;
      for (int i = 0; i < N; i++) begin
         ones = ones + W'(bits_in[i]);
      end
   end
endmodule

// File: rtl/wbc_grant_pick.sv
module wbc_grant_pick #(
   parameter int ISSUE_W = 4,
   parameter int LIM_W   = 3
) (
   input  logic [ISSUE_W-1:0] req,
   input  logic [LIM_W-1:0]   limit,
   output logic [ISSUE_W-1:0] gnt
);
   logic [LIM_W-1:0] taken;

   always_comb begin
      taken = '0;
      gnt   = '0;
      for (int i = 0; i < ISSUE_W; i++) begin
         if (req[i] && (taken < limit)) begin
            gnt[i] = 1'b1;
            taken  = taken + LIM_W'(1);
         end
      end
   end
endmodule

// File: rtl/wbc_credit_ctr.sv
module wbc_credit_ctr #(
   parameter int MAX   = 6,
   parameter int CNT_W = 3,
   parameter int INC_W = 3,
   parameter int DEC_W = 3,
   parameter int SUM_W = 5
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [INC_W-1:0] inc_n,
   input  logic [DEC_W-1:0] dec_n,
   output logic [CNT_W-1:0] cnt_q,
   output logic             err_q
);
   logic [SUM_W-1:0] sum;
   logic [SUM_W-1:0] diff;
   logic [CNT_W-1:0] cnt_d;
   logic             bad;

   always_comb begin
      sum  = SUM_W'(cnt_q) + SUM_W'(inc_n);
      diff = '0;
      bad  = 1'b0;
      if (sum < SUM_W'(dec_n)) begin
         cnt_d = '0;
         bad   = 1'b1;
      end else begin
         diff = sum - SUM_W'(dec_n);
         if (diff > SUM_W'(MAX)) begin
            cnt_d = CNT_W'(MAX);
            bad   = 1'b1;
         end else begin
            cnt_d = diff[CNT_W-1:0];
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_q <= '0;
         err_q <= 1'b0;
      end else begin
         cnt_q <= cnt_d;
         err_q <= err_q | bad;
      end
   end
endmodule

// File: rtl/wbc_tag_board.sv
module wbc_tag_board #(
   parameter int TAG_W = 4,
   parameter int N_SET = 4,
   parameter int N_CLR = 5
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic [N_SET-1:0]       set_vld,
   input  logic [N_SET*TAG_W-1:0] set_tag,
   input  logic [N_CLR-1:0]       clr_vld,
   input  logic [N_CLR*TAG_W-1:0] clr_tag,
   output logic                   err_q
);
   localparam int DEPTH = 1 << TAG_W;

   logic [DEPTH-1:0] live_q;
   logic [DEPTH-1:0] live_d;
   logic             miss;

   always_comb begin
      live_d = live_q;
      miss   = 1'b0;
      for (int k = 0; k < N_CLR; k++) begin
         if (clr_vld[k]) begin
            if (!live_q[clr_tag[k*TAG_W +: TAG_W]]) miss = 1'b1;
            live_d[clr_tag[k*TAG_W +: TAG_W]] = 1'b0;
         end
      end
      for (int s = 0; s < N_SET; s++) begin
         if (set_vld[s]) live_d[set_tag[s*TAG_W +: TAG_W]] = 1'b1;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         live_q <= '0;
         err_q  <= 1'b0;
      end else begin
         live_q <= live_d;
         err_q  <= err_q | miss;
      end
   end
endmodule

// File: rtl/wb_credit_throttle.sv
module wb_credit_throttle
   import wbc_pkg::*;
#(
   parameter int ISSUE_W    = 4,
   parameter int WB_WIDTH   = 2,
   parameter int WB_DEPTH   = 3,
   parameter int SQ_PORTS   = 2,
   parameter int LD_PORTS   = 1,
   parameter int TAG_W      = 4,
   parameter bit TRACK_TAGS = 1'b1
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic [ISSUE_W-1:0]        iss_req,
   input  logic [ISSUE_W*TAG_W-1:0]  iss_tag,
   output logic [ISSUE_W-1:0]        iss_gnt,
   output logic                      iss_enable,
   input  logic [WB_WIDTH-1:0]       wb_vld,
   input  logic [WB_WIDTH*TAG_W-1:0] wb_tag,
   input  logic [SQ_PORTS-1:0]       sq_vld,
   input  logic [SQ_PORTS*TAG_W-1:0] sq_tag,
   input  logic [LD_PORTS-1:0]       ld_vld,
   input  logic [LD_PORTS*TAG_W-1:0] ld_tag,
   output logic                      cnt_err,
   output logic                      tag_err
);
   localparam int MAX   = int'(wbc_credit_max(WB_WIDTH, WB_DEPTH));
   localparam int N_DEC = WB_WIDTH + SQ_PORTS + LD_PORTS;
   localparam int CNT_W = $clog2(MAX + 1);
   localparam int INC_W = $clog2(ISSUE_W + 1);
   localparam int DEC_W = $clog2(N_DEC + 1);
   localparam int SUM_W = $clog2(MAX + ISSUE_W + N_DEC + 1) + 1;

   if (ISSUE_W < 1 || WB_WIDTH < 1 || WB_DEPTH < 1) begin : g_bad_width
      $error("wb_credit_throttle: widths and depth must be at least 1");
   end
   if (SQ_PORTS < 1 || LD_PORTS < 1) begin : g_bad_ports
      $error("wb_credit_throttle: each return source needs a port");
   end
   if (TAG_W < 1 || TAG_W > 12) begin : g_bad_tag
      $error("wb_credit_throttle: TAG_W must be 1..12");
   end

   logic [N_DEC-1:0]       dec_vld;
   logic [N_DEC*TAG_W-1:0] dec_tag;
   logic [CNT_W-1:0]       cnt_q;
   logic [SUM_W-1:0]       avail;
   logic [INC_W-1:0]       limit;
   logic [INC_W-1:0]       inc_n;
   logic [DEC_W-1:0]       dec_n;

   assign dec_vld = {ld_vld, sq_vld, wb_vld};
   assign dec_tag = {ld_tag, sq_tag, wb_tag};

   always_comb begin
      avail = SUM_W'(MAX) - SUM_W'(cnt_q);
      if (avail > SUM_W'(ISSUE_W)) limit = INC_W'(ISSUE_W);
      else                         limit = avail[INC_W-1:0];
   end

   assign iss_enable = (cnt_q != CNT_W'(MAX));

   wbc_grant_pick #(.ISSUE_W(ISSUE_W), .LIM_W(INC_W)) u_pick (
      .req   (iss_req),
      .limit (limit),
      .gnt   (iss_gnt)
   );

   wbc_popcount #(.N(ISSUE_W), .W(INC_W)) u_inc_cnt (
      .bits_in (iss_gnt),
      .ones    (inc_n)
   );

   wbc_popcount #(.N(N_DEC), .W(DEC_W)) u_dec_cnt (
      .bits_in (dec_vld),
      .ones    (dec_n)
   );

   wbc_credit_ctr #(
      .MAX(MAX), .CNT_W(CNT_W), .INC_W(INC_W), .DEC_W(DEC_W), .SUM_W(SUM_W)
   ) u_ctr (
      .clk   (clk),
      .rst_n (rst_n),
      .inc_n (inc_n),
      .dec_n (dec_n),
      .cnt_q (cnt_q),
      .err_q (cnt_err)
   );

   if (TRACK_TAGS) begin : g_tags
      wbc_tag_board #(.TAG_W(TAG_W), .N_SET(ISSUE_W), .N_CLR(N_DEC)) u_board (
         .clk     (clk),
         .rst_n   (rst_n),
         .set_vld (iss_gnt),
         .set_tag (iss_tag),
         .clr_vld (dec_vld),
         .clr_tag (dec_tag),
         .err_q   (tag_err)
      );
   end else begin : g_no_tags
      assign tag_err = 1'b0;
   end
endmodule

// File: rtl/wbc_checker.sv
module wbc_checker #(
   parameter int ISSUE_W  = 4,
   parameter int WB_WIDTH = 2,
   parameter int SQ_PORTS = 2,
   parameter int LD_PORTS = 1,
   parameter int MAX      = 6,
   parameter int CNT_W    = 3
) (
   input logic                clk,
   input logic                rst_n,
   input logic [ISSUE_W-1:0]  iss_req,
   input logic [ISSUE_W-1:0]  iss_gnt,
   input logic                iss_enable,
   input logic [WB_WIDTH-1:0] wb_vld,
   input logic [SQ_PORTS-1:0] sq_vld,
   input logic [LD_PORTS-1:0] ld_vld,
   input logic                cnt_err,
   input logic                tag_err,
   input logic [CNT_W-1:0]    cnt_q
);
   logic               ret_any;
   logic [ISSUE_W-1:0] skipped;
   logic [ISSUE_W-1:0] first_skip;
   logic [ISSUE_W-1:0] below_skip;

   assign ret_any    = (|wb_vld) | (|sq_vld) | (|ld_vld);
   assign skipped    = iss_req & ~iss_gnt;
   assign first_skip = skipped & (~skipped + ISSUE_W'(1));
   assign below_skip = first_skip - ISSUE_W'(1);

   AST_RESET_OPEN: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> (iss_enable && !cnt_err && !tag_err)); // R2
   AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      int'(cnt_q) <= MAX); // R1
   AST_CLOSED_NO_GNT: assert property (@(posedge clk) disable iff (!rst_n)
      !iss_enable |-> (iss_gnt == '0)); // R3
   AST_CLOSED_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      (!iss_enable && !ret_any) |=> !iss_enable); // R3
   AST_INC_BY_GNT: assert property (@(posedge clk) disable iff (!rst_n)
      (!ret_any && !cnt_err) |=> (int'(cnt_q) == int'($past(cnt_q)) + $countones($past(iss_gnt)))); // R3
   AST_REOPEN: assert property (@(posedge clk) disable iff (!rst_n)
      (!iss_enable && ret_any) |=> iss_enable); // R4
   AST_GNT_NEEDS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
      (iss_gnt & ~iss_req) == '0); // R6
   AST_GNT_LOW_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
      (skipped != '0) |-> ((iss_gnt & ~below_skip) == '0)); // R6
   AST_GNT_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(iss_gnt) <= MAX - int'(cnt_q)); // R6
   AST_CNT_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_err |=> cnt_err); // R8
   AST_TAG_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      tag_err |=> tag_err); // R9
endmodule

bind wb_credit_throttle wbc_checker #(
   .ISSUE_W(ISSUE_W), .WB_WIDTH(WB_WIDTH), .SQ_PORTS(SQ_PORTS),
   .LD_PORTS(LD_PORTS), .MAX(MAX), .CNT_W(CNT_W)
) u_wbc_checker (
   .clk(clk), .rst_n(rst_n), .iss_req(iss_req), .iss_gnt(iss_gnt),
   .iss_enable(iss_enable), .wb_vld(wb_vld), .sq_vld(sq_vld), .ld_vld(ld_vld),
   .cnt_err(cnt_err), .tag_err(tag_err), .cnt_q(cnt_q)
);

// File: tb/test_wb_credit_throttle.sv
`timescale 1ns/1ps
module test_wb_credit_throttle;
   localparam int IW   = 4;
   localparam int WBW  = 2;
   localparam int WBD  = 3;
   localparam int SQP  = 2;
   localparam int LDP  = 1;
   localparam int TW   = 4;
   localparam int MAXC = WBW * WBD;
   localparam int NTAG = 1 << TW;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic [IW-1:0]     iss_req = '0;
   logic [IW*TW-1:0]  iss_tag = '0;
   logic [IW-1:0]     iss_gnt;
   logic              iss_enable;
   logic [WBW-1:0]    wb_vld = '0;
   logic [WBW*TW-1:0] wb_tag = '0;
   logic [SQP-1:0]    sq_vld = '0;
   logic [SQP*TW-1:0] sq_tag = '0;
   logic [LDP-1:0]    ld_vld = '0;
   logic [LDP*TW-1:0] ld_tag = '0;
   logic              cnt_err;
   logic              tag_err;

   always #2.5 clk = ~clk;

   wb_credit_throttle #(
      .ISSUE_W(IW), .WB_WIDTH(WBW), .WB_DEPTH(WBD), .SQ_PORTS(SQP),
      .LD_PORTS(LDP), .TAG_W(TW), .TRACK_TAGS(1'b1)
   ) i_wb_credit_throttle (
      .clk(clk), .rst_n(rst_n), .iss_req(iss_req), .iss_tag(iss_tag),
      .iss_gnt(iss_gnt), .iss_enable(iss_enable), .wb_vld(wb_vld),
      .wb_tag(wb_tag), .sq_vld(sq_vld), .sq_tag(sq_tag), .ld_vld(ld_vld),
      .ld_tag(ld_tag), .cnt_err(cnt_err), .tag_err(tag_err)
   );

   // staged stimulus, copied to the ports at the falling edge
   logic [IW-1:0]     s_req;
   logic [IW*TW-1:0]  s_itag;
   logic [WBW-1:0]    s_wb;
   logic [WBW*TW-1:0] s_wbt;
   logic [SQP-1:0]    s_sq;
   logic [SQP*TW-1:0] s_sqt;
   logic [LDP-1:0]    s_ld;
   logic [LDP*TW-1:0] s_ldt;

   // behavioural reference
   int m_cnt;
   bit m_cerr, m_terr;
   bit rec [int];
   int n_cmp = 0, n_bad = 0;
   bit done = 1'b0;

   task automatic cmp(input string tag, input int act, input int exp);
      n_cmp++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
      end
   endtask

   task automatic idle();
      s_req = '0; s_itag = '0; s_wb = '0; s_wbt = '0;
      s_sq = '0; s_sqt = '0; s_ld = '0; s_ldt = '0;
   endtask

   task automatic give_tags();
      bit used [int];
      int t = 0;
      for (int s = 0; s < IW; s++) begin
         while (rec.exists(t) || used.exists(t)) t = (t + 1) % NTAG;
         used[t] = 1'b1;
         s_itag[s*TW +: TW] = TW'(t);
      end
   endtask

   // returns up to the given counts per source, taken from live tags
   task automatic pick_ret(input int nwb, input int nsq, input int nld);
      int live[$];
      int k = 0;
      foreach (rec[t]) live.push_back(t);
      for (int i = 0; i < nwb && k < live.size(); i++) begin
         s_wb[i] = 1'b1; s_wbt[i*TW +: TW] = TW'(live[k]); k++;
      end
      for (int i = 0; i < nsq && k < live.size(); i++) begin
         s_sq[i] = 1'b1; s_sqt[i*TW +: TW] = TW'(live[k]); k++;
      end
      for (int i = 0; i < nld && k < live.size(); i++) begin
         s_ld[i] = 1'b1; s_ldt[i*TW +: TW] = TW'(live[k]); k++;
      end
   endtask

   task automatic do_cycle();
      int lim, taken, d;
      logic [IW-1:0] eg;
      int rets[$];
      @(negedge clk);
      iss_req = s_req; iss_tag = s_itag; wb_vld = s_wb; wb_tag = s_wbt;
      sq_vld = s_sq; sq_tag = s_sqt; ld_vld = s_ld; ld_tag = s_ldt;
      #1;
      lim = (MAXC - m_cnt < IW) ? MAXC - m_cnt : IW;
      taken = 0; eg = '0;
      for (int s = 0; s < IW; s++)
         if (s_req[s] && taken < lim) begin eg[s] = 1'b1; taken++; end
      cmp("R6 R7 grant vector", int'(iss_gnt), int'(eg));
      cmp("R1 R3 R4 issue enable", int'(iss_enable), int'(m_cnt != MAXC));
      cmp("R8 count error", int'(cnt_err), int'(m_cerr));
      cmp("R9 tag error", int'(tag_err), int'(m_terr));
      for (int i = 0; i < WBW; i++) if (s_wb[i]) rets.push_back(int'(s_wbt[i*TW +: TW]));
      for (int i = 0; i < SQP; i++) if (s_sq[i]) rets.push_back(int'(s_sqt[i*TW +: TW]));
      for (int i = 0; i < LDP; i++) if (s_ld[i]) rets.push_back(int'(s_ldt[i*TW +: TW]));
      d = rets.size();
      foreach (rets[i]) if (!rec.exists(rets[i])) m_terr = 1'b1;
      foreach (rets[i]) if (rec.exists(rets[i])) rec.delete(rets[i]);
      for (int s = 0; s < IW; s++) if (eg[s]) rec[int'(s_itag[s*TW +: TW])] = 1'b1;
      if (m_cnt + taken < d) begin m_cnt = 0; m_cerr = 1'b1; end
      else m_cnt = m_cnt + taken - d;
   endtask

   initial begin
      int g;
      idle();
      m_cnt = 0; m_cerr = 1'b0; m_terr = 1'b0;
      repeat (4) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      #1;
      cmp("R2 enable after reset", int'(iss_enable), 1);
      cmp("R2 cnt_err after reset", int'(cnt_err), 0);
      cmp("R2 tag_err after reset", int'(tag_err), 0);

      // R3/R6: fill from empty, second burst clipped by the limit
      idle(); s_req = '1; give_tags(); do_cycle();
      cmp("R6 full-width burst", int'(iss_gnt), 4'b1111);
      idle(); s_req = '1; give_tags(); do_cycle();
      cmp("R6 burst clipped to two credits", int'(iss_gnt), 4'b0011);
      idle(); s_req = 4'b0110; give_tags(); do_cycle();
      cmp("R3 closed at limit", int'(iss_enable), 0);

      // R7/R4/R5: one return per source at the full point
      for (int src = 0; src < 3; src++) begin
         idle(); s_req = '1; give_tags();
         pick_ret(src == 0 ? 1 : 0, src == 1 ? 1 : 0, src == 2 ? 1 : 0);
         do_cycle();
         cmp("R7 no grant in return cycle", int'(iss_gnt), 0);
         idle(); s_req = 4'b1010; give_tags(); do_cycle();
         cmp("R4 R5 reopened after one return", int'(iss_gnt), 4'b0010);
      end

      // mixed random traffic
      for (int c = 0; c < 800; c++) begin
         idle();
         s_req = IW'($urandom);
         give_tags();
         pick_ret($urandom_range(0, WBW), $urandom_range(0, SQP), $urandom_range(0, LDP));
         do_cycle();
      end

      // drain through all sources
      for (int c = 0; c < 20 && rec.size() > 0; c++) begin
         idle(); pick_ret(WBW, SQP, LDP); do_cycle();
      end
      idle(); do_cycle();
      cmp("R5 drained count reopens", int'(iss_enable), 1);

      // R9: return of a tag never issued
      idle(); s_req = 4'b0001; give_tags(); do_cycle();
      idle();
      g = 0;
      while (rec.exists(g)) g++;
      s_sq[0] = 1'b1; s_sqt[TW-1:0] = TW'(g);
      do_cycle();
      idle(); do_cycle();
      cmp("R9 unknown tag flagged", int'(tag_err), 1);
      cmp("R9 no count error yet", int'(cnt_err), 0);

      // R8: return while already empty
      idle(); pick_ret(0, 0, 0);
      foreach (rec[t]) rec.delete(t);
      s_ld[0] = 1'b1; s_ldt[TW-1:0] = '0;
      s_wb = '1;
      do_cycle();
      idle(); do_cycle();
      cmp("R8 underflow flagged", int'(cnt_err), 1);
      idle(); s_req = '1; give_tags(); do_cycle();
      cmp("R8 count clamped to zero", int'(iss_gnt), 4'b1111);
      idle(); do_cycle();

      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_bad++;
         $display("FAIL watchdog R1..R9 run: actual hung expected finished");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end
endmodule